// File: doc/BRIEF.md
# Thermometer-to-Gray Encoder with Pipelined Binary Conversion

This block sits behind a bank of comparators in a parallel-conversion datapath. It takes the comparator word as a thermometer vector of 2^N−1 levels and encodes it straight to an N-bit Gray code, with no one-hot boundary word in between. Every level bit drives exactly one encoder term, so no comparator output is loaded by several gates. A wrong or uncertain level bit can therefore disturb at most one Gray bit.

The Gray code is registered and then turned into binary by an XOR ripple from the MSB down. The ripple is cut by a register after every `XOR_PER_STAGE` XOR levels. The Gray code and the valid flag travel alongside the ripple, so both output codes and `valid_o` come out aligned. A new word can be taken every cycle. The latency is 1 + ceil((N−1)/XOR_PER_STAGE) cycles.

Top module: `therm_gray_conv`

## Requirements
- R1: For a valid thermometer word of level c (bit i of `therm_i`, for i = 0 .. 2^N−2, is 1 exactly when i < c), `gray_o` equals c XOR (c >> 1).
- R2: For a valid thermometer word of level c, `bin_o` equals c.
- R3: An all-zero input gives 0 on both `gray_o` and `bin_o`. An all-one input gives `bin_o` = 2^N−1 and `gray_o` = (2^N−1) XOR ((2^N−1) >> 1).
- R4: The Gray outputs for levels c and c+1 differ in exactly one bit.
- R5: If any single bit of a valid level-c word is inverted, `gray_o` differs from c XOR (c >> 1) in at most one bit.
- R6: A single bubble next to the transition gives |`bin_o` − c| ≤ 3. Such a bubble is either level c−1 cleared (bit index c−2, for c ≥ 2) or level c+2 set (bit index c+1, for c ≤ 2^N−3).
- R7: For any input word, `bin_o` is the binary value of `gray_o`: bin[N−1] = gray[N−1] and bin[k] = bin[k+1] XOR gray[k].
- R8: `valid_o` and the matching codes appear exactly LAT = 1 + ceil((N−1)/XOR_PER_STAGE) cycles after `valid_i` is sampled high. Words presented on consecutive cycles come out on consecutive cycles, in order.
- R9: While `rst_ni` is low, `valid_o`, `gray_o` and `bin_o` are 0.
- R10: When `valid_i` has been low for LAT cycles, `valid_o` is low, whatever `therm_i` carries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Input word strobe |
| therm_i | input | 2^N−1 | Comparator levels; bit i is level i+1 |
| valid_o | output | 1 | Output codes valid |
| gray_o | output | N | Gray-coded level |
| bin_o | output | N | Binary level |

## Verification
The bench runs every level through the block. It checks both codes and the one-bit step between neighbouring Gray codes. An encoder that took a term from the wrong pair of levels would give wrong codes, or would step two bits at once at a power-of-two boundary. Every single-bit inversion of every level is applied next. Any fan-out from a level bit into two terms would then show up as a two-bit Gray error, and a wrong stage slice in the ripple would break the Gray-to-binary relation. Bubbles next to the transition are then checked against the ±3 bound. A back-to-back stream follows, which catches a valid flag that is not delayed to match the data, or a stage that drops or repeats a word.

// File: rtl/therm_gray_pkg.sv
`timescale 1ns/1ps
package therm_gray_pkg;

  function automatic int conv_stages(int n, int xps);
    return (n - 1 + xps - 1) / xps;
  endfunction

  function automatic int total_latency(int n, int xps);
    return 1 + conv_stages(n, xps);
  endfunction

endpackage

// File: rtl/therm_gray_enc.sv
`timescale 1ns/1ps
module therm_gray_enc #(
  parameter  int N  = 4,
  localparam int TW = (1 << N) - 1
) (
  input  logic [TW-1:0] therm_i,
  output logic [N-1:0]  gray_o
);

  // level L sits at therm_i[L-1]; MSB is the mid-scale level
  assign gray_o[N-1] = therm_i[(1 << (N-1)) - 1];

  for (genvar k = 0; k < N-1; k++) begin : g_bit
    localparam int NP = 1 << (N - k - 2);
    logic [NP-1:0] hit;
    for (genvar m = 0; m < NP; m++) begin : g_pair
      localparam int LO = ((4*m + 1) << k) - 1;
      localparam int HI = ((4*m + 3) << k) - 1;
      assign hit[m] = therm_i[LO] & ~therm_i[HI];
    end
    assign gray_o[k] = |hit;
  end

endmodule

// File: rtl/gray_bin_pipe.sv
`timescale 1ns/1ps
module gray_bin_pipe
  import therm_gray_pkg::*;
#(
  parameter int N   = 4,
  parameter int XPS = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         valid_i,
  input  logic [N-1:0] gray_i,
  output logic         valid_o,
  output logic [N-1:0] gray_o,
  output logic [N-1:0] bin_o
);

  localparam int NS = conv_stages(N, XPS);

  for (genvar s = 0; s <= NS; s++) begin : g_stg
    logic [N-1:0] g_q;
    logic [N-1:0] b_q;
    logic         v_q;

    if (s == 0) begin : g_in
      assign g_q = gray_i;
      assign b_q = {gray_i[N-1], {(N-1){1'b0}}};
      assign v_q = valid_i;
    end else begin : g_reg
      localparam int HI  = N - 2 - (s - 1) * XPS;
      localparam int LO  = (HI - XPS + 1 < 0) ? 0 : HI - XPS + 1;
      logic [N-1:0] b_nx;

      always_comb begin
        b_nx = g_stg[s-1].b_q;
        for (int k = HI; k >= LO; k--) begin
          b_nx[k] = b_nx[k+1] ^ g_stg[s-1].g_q[k];
        end
      end

      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          v_q <= 1'b0;
          g_q <= '0;
          b_q <= '0;
        end else begin
          v_q <= g_stg[s-1].v_q;
          g_q <= g_stg[s-1].g_q;
          b_q <= b_nx;
        end
      end
    end
  end

  assign valid_o = g_stg[NS].v_q;
  assign gray_o  = g_stg[NS].g_q;
  assign bin_o   = g_stg[NS].b_q;

endmodule

// File: rtl/therm_gray_conv.sv
`timescale 1ns/1ps
module therm_gray_conv #(
  parameter  int N             = 4,
  parameter  int XOR_PER_STAGE = 2,
  localparam int TW            = (1 << N) - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          valid_i,
  input  logic [TW-1:0] therm_i,
  output logic          valid_o,
  output logic [N-1:0]  gray_o,
  output logic [N-1:0]  bin_o
);

  logic [N-1:0] enc_gray;
  logic [N-1:0] enc_q;
  logic         enc_v_q;

  therm_gray_enc #(.N(N)) u_enc (
    .therm_i (therm_i),
    .gray_o  (enc_gray)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      enc_q   <= '0;
      enc_v_q <= 1'b0;
    end else begin
      enc_q   <= enc_gray;
      enc_v_q <= valid_i;
    end
  end

  gray_bin_pipe #(.N(N), .XPS(XOR_PER_STAGE)) u_pipe (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .valid_i (enc_v_q),
    .gray_i  (enc_q),
    .valid_o (valid_o),
    .gray_o  (gray_o),
    .bin_o   (bin_o)
  );

endmodule

module therm_gray_conv_chk
  import therm_gray_pkg::*;
#(
  parameter int N   = 4,
  parameter int XPS = 2
) (
  input logic         clk_i,
  input logic         rst_ni,
  input logic         valid_i,
  input logic         valid_o,
  input logic [N-1:0] gray_o,
  input logic [N-1:0] bin_o
);

  localparam int          LAT  = total_latency(N, XPS);
  localparam int          QW   = $clog2(LAT + 1) + 1;
  localparam logic [N-1:0] MAXC = {N{1'b1}};

  function automatic logic [N-1:0] to_bin(logic [N-1:0] g);
    logic [N-1:0] b;
    b[N-1] = g[N-1];
    for (int k = N - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     quiet_q <= '0;
    else if (valid_i)                quiet_q <= '0;
    else if (quiet_q < QW'(LAT))     quiet_q <= quiet_q + 1'b1;
  end

  p_gray_bin_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> bin_o == to_bin(gray_o));

  p_full_scale_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && gray_o == (MAXC ^ (MAXC >> 1))) |-> bin_o == MAXC);

  p_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && gray_o == '0) |-> bin_o == '0);

  p_reset_r9: assert property (@(posedge clk_i)
    !rst_ni |=> (!valid_o && gray_o == '0 && bin_o == '0));

  p_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q >= QW'(LAT)) |-> !valid_o);

endmodule

bind therm_gray_conv therm_gray_conv_chk #(.N(N), .XPS(XOR_PER_STAGE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .valid_i (valid_i),
  .valid_o (valid_o),
  .gray_o  (gray_o),
  .bin_o   (bin_o)
);

// File: tb/therm_gray_conv_test.sv
`timescale 1ns/1ps
module therm_gray_conv_test;

  localparam int N    = 4;
  localparam int XPS  = 2;
  localparam int TW   = (1 << N) - 1;
  localparam int MAXC = (1 << N) - 1;
  localparam int BLAT = 1 + (N - 1 + XPS - 1) / XPS;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          valid_i = 1'b0;
  logic [TW-1:0] therm_i = '0;
  logic          valid_o;
  logic [N-1:0]  gray_o;
  logic [N-1:0]  bin_o;

  int nchk = 0;
  int nerr = 0;

  always #5 clk = ~clk;

  therm_gray_conv #(.N(N), .XOR_PER_STAGE(XPS)) uut (
    .clk_i   (clk),
    .rst_ni  (rst_ni),
    .valid_i (valid_i),
    .therm_i (therm_i),
    .valid_o (valid_o),
    .gray_o  (gray_o),
    .bin_o   (bin_o)
  );

  function automatic logic [TW-1:0] therm(int c);
    logic [TW-1:0] w;
    for (int i = 0; i < TW; i++) w[i] = (i < c);
    return w;
  endfunction

  function automatic logic [N-1:0] gray_of(int c);
    logic [N-1:0] v = N'(c);
    return v ^ (v >> 1);
  endfunction

  function automatic logic [N-1:0] bin_of(logic [N-1:0] g);
    logic [N-1:0] b;
    b[N-1] = g[N-1];
    for (int k = N - 2; k >= 0; k--) b[k] = b[k+1] ^ g[k];
    return b;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  // one isolated word; checks exact latency (R8), returns the codes
  task automatic send(input logic [TW-1:0] w, output logic [N-1:0] g, output logic [N-1:0] b);
    @(negedge clk);
    therm_i = w;
    valid_i = 1'b1;
    @(negedge clk);
    valid_i = 1'b0;
    therm_i = '0;
    repeat (BLAT - 2) @(negedge clk);
    check(valid_o == 1'b0, "R8 early", int'(valid_o), 0);
    @(negedge clk);
    check(valid_o == 1'b1, "R8 on time", int'(valid_o), 1);
    g = gray_o;
    b = bin_o;
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    check(valid_o == 1'b0, "R9 valid", int'(valid_o), 0);
    check(gray_o == '0, "R9 gray", int'(gray_o), 0);
    check(bin_o == '0, "R9 bin", int'(bin_o), 0);
    rst_ni = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_sweep();
    logic [N-1:0] g, b, pg;
    pg = '0;
    for (int c = 0; c <= MAXC; c++) begin
      send(therm(c), g, b);
      check(g == gray_of(c), "R1", int'(g), int'(gray_of(c)));
      check(int'(b) == c, "R2", int'(b), c);
      if (c == 0 || c == MAXC) begin
        check(int'(b) == c && g == gray_of(c), "R3", int'(b), c);
      end
      if (c > 0) begin
        check($countones(g ^ pg) == 1, "R4", $countones(g ^ pg), 1);
      end
      pg = g;
    end
  endtask

  task automatic t_stream();
    for (int i = 0; i <= MAXC + BLAT; i++) begin
      @(negedge clk);
      if (i >= BLAT) begin
        int c = MAXC - (i - BLAT);
        check(valid_o == 1'b1, "R8 stream valid", int'(valid_o), 1);
        check(int'(bin_o) == c, "R8 stream bin", int'(bin_o), c);
        check(gray_o == gray_of(c), "R8 stream gray", int'(gray_o), int'(gray_of(c)));
      end
      if (i <= MAXC) begin
        therm_i = therm(MAXC - i);
        valid_i = 1'b1;
      end else begin
        therm_i = '0;
        valid_i = 1'b0;
      end
    end
  endtask

  task automatic t_idle();
    for (int i = 0; i < 3 * BLAT; i++) begin
      @(negedge clk);
      therm_i = TW'(32'h5A5A_3C3C >> i);
      check(valid_o == 1'b0, "R10", int'(valid_o), 0);
    end
    therm_i = '0;
  endtask

  task automatic t_flip();
    logic [N-1:0] g, b;
    for (int c = 0; c <= MAXC; c++) begin
      for (int i = 0; i < TW; i++) begin
        send(therm(c) ^ (TW'(1) << i), g, b);
        check($countones(g ^ gray_of(c)) <= 1, "R5", $countones(g ^ gray_of(c)), 1);
        check(b == bin_of(g), "R7", int'(b), int'(bin_of(g)));
      end
    end
  endtask

  task automatic t_bubble();
    logic [N-1:0] g, b;
    logic [TW-1:0] w;
    int d;
    for (int c = 0; c <= MAXC; c++) begin
      if (c >= 2) begin
        w = therm(c);
        w[c-2] = 1'b0;
        send(w, g, b);
        d = int'(b) - c;
        if (d < 0) d = -d;
        check(d <= 3, "R6 hole", int'(b), c);
      end
      if (c <= MAXC - 2) begin
        w = therm(c);
        w[c+1] = 1'b1;
        send(w, g, b);
        d = int'(b) - c;
        if (d < 0) d = -d;
        check(d <= 3, "R6 stray", int'(b), c);
      end
    end
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_stream();
    t_idle();
    t_flip();
    t_bubble();
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

endmodule